// File: doc/BRIEF.md
# Gamepad Serial Link Responder

This block plays the device side of a console gamepad link that behaves like SPI. The host pulls an active-low select line, clocks bytes out on its command line with a clock that idles high, and reads bytes back on the responder's data line. Bits travel least significant first. The responder changes its data bit after each falling host clock edge, and the host samples on the rising edge. After every byte that is not the last in the frame, the responder drops an active-low acknowledge line for a short pulse. This tells the host that a device is present and that another byte follows.

Every frame starts with three handshake bytes. The responder sends back 0xFF, then an identity byte that encodes the current reporting mode and the payload length, then 0x5A. A poll command returns button state, plus four stick bytes when the pad is in analog mode. Two further commands move the pad into and out of a configuration mode, and select digital or analog reporting while it is configured. Button and stick values come from parallel input ports. They are captured once per frame, when select falls, so that one frame always reports a single consistent picture. Host clock, select and command are brought into the system clock domain by two-flop synchronisers, and all decisions are taken on the edges detected after them.

Top module: `pad_link_responder`

## Requirements
- R1: While `sel_n` is high, and from reset, `miso` and `ack_n` are both high, once the input synchronisers have caught up.
- R2: Data is sent LSB first, and each bit changes after a falling `sck` edge. If the first host byte is 0x01 and the command is supported, the reply to bytes 0 and 2 is 0xFF and 0x5A.
- R3: The reply to byte 1 is the identity byte: 0x41 in digital mode, 0x73 in analog mode and 0xF3 in configuration mode. Its low nibble gives the payload in 16-bit halfwords, so a frame is 5 bytes long in digital mode and 9 bytes otherwise. After reset the pad is in digital mode and not configured.
- R4: For command 0x42, payload byte 0 is the bitwise inverse of `btn_i[7:0]` and payload byte 1 is the inverse of `btn_i[15:8]`, so a pressed button (input 1) reads as 0. The values are those present when `sel_n` fell.
- R5: In analog and configuration mode, the 0x42 reply continues with `rx_i`, `ry_i`, `lx_i` and `ly_i`, in that order.
- R6: After each byte except the last byte of the frame, `ack_n` goes low for exactly ACK_LEN system clocks. The pulse starts no earlier than the eighth rising `sck` edge of that frame.
- R7: Command 0x43 with payload byte 0 equal to 0x01 enters configuration mode. With 0x00 it leaves configuration mode and returns to the mode selected last. The change takes effect when the final byte of the frame completes.
- R8: Command 0x44 is accepted only in configuration mode. Payload byte 0 equal to 0x01 selects analog and 0x00 selects digital. Every payload reply byte of 0x43 and 0x44 is 0x00.
- R9: If the first host byte is not 0x01, or the command byte is unknown, or 0x44 arrives outside configuration mode, every later byte of the frame is 0xFF and no later byte is acknowledged. The mode does not change.
- R10: If `sel_n` rises before the frame's final byte, the frame is dropped. The data line returns high, no acknowledge follows, and the partly received command leaves the mode unchanged.
- R11: Bytes clocked beyond the frame length read 0xFF and get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Host attention select, active low |
| sck | input | 1 | Host serial clock, idles high |
| mosi | input | 1 | Host command bit |
| btn_i | input | 16 | Button levels, 1 = pressed; bits 7:0 are poll byte 0, bits 15:8 are poll byte 1 |
| rx_i | input | 8 | Right stick X (0x00 left, 0xFF right) |
| ry_i | input | 8 | Right stick Y (0x00 up, 0xFF down) |
| lx_i | input | 8 | Left stick X |
| ly_i | input | 8 | Left stick Y |
| miso | output | 1 | Responder data bit |
| ack_n | output | 1 | Per-byte acknowledge pulse, active low |

## Verification
The hardest cases to reach are the ones that depend on mode history. A 0x44 command has an effect only after a full enter-configuration frame. The analog identity only shows up after an enter, set, exit sequence. An aborted enter frame can only be seen as harmless by polling again afterwards. The stimulus therefore walks the pad through those command chains in a fixed order. It cuts one frame after its argument byte has arrived but before its final byte, and injects frames with a wrong lead byte or an unknown command. Between these steps, random button and stick patterns are polled in whichever mode is current.

// File: rtl/pad_link_pkg.sv
package pad_link_pkg;
  localparam logic [7:0] LEAD_BYTE = 8'h01;
  localparam logic [7:0] PAD_BYTE  = 8'h5A;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam logic [7:0] ZERO_BYTE = 8'h00;
  localparam logic [7:0] OP_POLL   = 8'h42;
  localparam logic [7:0] OP_CFG    = 8'h43;
  localparam logic [7:0] OP_MODE   = 8'h44;
  localparam logic [7:0] ARG_ON    = 8'h01;
  localparam logic [7:0] ARG_OFF   = 8'h00;
  localparam logic [7:0] ID_DIG    = 8'h41;
  localparam logic [7:0] ID_ANA    = 8'h73;
  localparam logic [7:0] ID_CFG    = 8'hF3;

  typedef enum logic [1:0] {OPK_POLL, OPK_CFG, OPK_MODE, OPK_NONE} op_kind_e;

  typedef struct packed {
    logic [15:0] btn;
    logic [7:0]  rx;
    logic [7:0]  ry;
    logic [7:0]  lx;
    logic [7:0]  ly;
  } pad_state_t;

  // header of three bytes plus two bytes per halfword named in the id nibble
  function automatic logic [3:0] frame_len(logic [7:0] id);
    return 4'd3 + {id[2:0], 1'b0};
  endfunction
endpackage

// File: rtl/pad_link_sync.sv
module pad_link_sync #(
  parameter int             W    = 3,
  parameter logic [W-1:0]   INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st_q;
    logic       prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= {2{INIT[i]}};
        prev_q <= INIT[i];
      end else begin
        st_q   <= {st_q[0], din[i]};
        prev_q <= st_q[1];
      end
    end
    assign lvl[i]  = st_q[1];
    assign rise[i] = st_q[1] & ~prev_q;
    assign fall[i] = ~st_q[1] & prev_q;
  end
endmodule

// File: rtl/pad_link_shift.sv
module pad_link_shift
  import pad_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sck_fall,
  input  logic       sck_rise,
  input  logic       mosi_s,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       miso,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  logic [2:0] bit_q;
  logic [7:0] tx_q;
  logic [7:0] rx_q;
  logic       miso_q;
  logic       done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      tx_q   <= IDLE_BYTE;
      rx_q   <= '0;
      miso_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        bit_q  <= '0;
        tx_q   <= IDLE_BYTE;
        miso_q <= 1'b1;
      end else begin
        if (load)     tx_q   <= load_byte;
        if (sck_fall) miso_q <= tx_q[bit_q];
        if (sck_rise) begin
          rx_q  <= {mosi_s, rx_q[7:1]};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) done_q <= 1'b1;
        end
      end
    end
  end

  assign miso      = miso_q;
  assign rx_byte   = rx_q;
  assign byte_done = done_q;
endmodule

// File: rtl/pad_link_proto.sv
module pad_link_proto
  import pad_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       start,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  pad_state_t pad_in,
  output logic       load,
  output logic [7:0] load_byte,
  output logic       ack_req
);
  logic [3:0] idx_q, nxt, len, pj;
  op_kind_e   op_q, op_n;
  logic       mute_q, mute_n, last;
  logic [7:0] arg_q, id_cur, poll_b;
  pad_state_t snap_q;
  logic       cfg_q, ana_q;

  always_comb begin
    id_cur = cfg_q ? ID_CFG : (ana_q ? ID_ANA : ID_DIG);
    len    = frame_len(id_cur);
    op_n   = op_q;
    if (idx_q == 4'd1) begin
      case (rx_byte)
        OP_POLL: op_n = OPK_POLL;
        OP_CFG:  op_n = OPK_CFG;
        OP_MODE: op_n = cfg_q ? OPK_MODE : OPK_NONE;
        default: op_n = OPK_NONE;
      endcase
    end
    mute_n = mute_q | ((idx_q == 4'd0) && (rx_byte != LEAD_BYTE))
                    | ((idx_q == 4'd1) && (op_n == OPK_NONE));
    last   = (idx_q == len - 4'd1);
    nxt    = (idx_q == 4'hF) ? idx_q : idx_q + 4'd1;
    pj     = nxt - 4'd3;
    case (pj)
      4'd0:    poll_b = ~snap_q.btn[7:0];
      4'd1:    poll_b = ~snap_q.btn[15:8];
      4'd2:    poll_b = snap_q.rx;
      4'd3:    poll_b = snap_q.ry;
      4'd4:    poll_b = snap_q.lx;
      default: poll_b = snap_q.ly;
    endcase
    if (mute_n || nxt >= len)   load_byte = IDLE_BYTE;
    else if (nxt == 4'd1)       load_byte = id_cur;
    else if (nxt == 4'd2)       load_byte = PAD_BYTE;
    else if (op_n == OPK_POLL)  load_byte = poll_b;
    else                        load_byte = ZERO_BYTE;
    load    = byte_done;
    ack_req = byte_done && !mute_n && (idx_q < len - 4'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      op_q   <= OPK_NONE;
      mute_q <= 1'b0;
      arg_q  <= '0;
      snap_q <= '0;
      cfg_q  <= 1'b0;
      ana_q  <= 1'b0;
    end else if (!active) begin
      idx_q  <= '0;
      op_q   <= OPK_NONE;
      mute_q <= 1'b0;
    end else begin
      if (start) snap_q <= pad_in;
      if (byte_done) begin
        idx_q  <= nxt;
        op_q   <= op_n;
        mute_q <= mute_n;
        if (idx_q == 4'd3) arg_q <= rx_byte;
        if (last && !mute_n) begin
          if (op_n == OPK_CFG) begin
            if (arg_q == ARG_ON)       cfg_q <= 1'b1;
            else if (arg_q == ARG_OFF) cfg_q <= 1'b0;
          end else if (op_n == OPK_MODE) begin
            if (arg_q == ARG_ON)       ana_q <= 1'b1;
            else if (arg_q == ARG_OFF) ana_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pad_link_ack.sv
module pad_link_ack #(
  parameter int DELAY = 4,
  parameter int LEN   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic trig,
  output logic ack_n
);
  localparam int TOTAL = DELAY + LEN;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          ack_q;

  always_comb begin
    if (!active)            cnt_n = '0;
    else if (trig)          cnt_n = CW'(TOTAL);
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
    else                    cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ack_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      ack_q <= !((cnt_n != '0) && (cnt_n <= CW'(LEN)));
    end
  end

  assign ack_n = ack_q;
endmodule

// File: rtl/pad_link_responder.sv
module pad_link_responder
  import pad_link_pkg::*;
#(
  parameter int ACK_DELAY = 4,
  parameter int ACK_LEN   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        sck,
  input  logic        mosi,
  input  logic [15:0] btn_i,
  input  logic [7:0]  rx_i,
  input  logic [7:0]  ry_i,
  input  logic [7:0]  lx_i,
  input  logic [7:0]  ly_i,
  output logic        miso,
  output logic        ack_n
);
  logic [2:0] s_lvl, s_rise, s_fall;
  logic       active, start, load, byte_done, ack_req;
  logic [7:0] rx_byte, load_byte;
  pad_state_t pad_in;

  pad_link_sync #(.W(3), .INIT(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mosi, sck, sel_n}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign active = ~s_lvl[0];
  assign start  = s_fall[0];
  assign pad_in = '{btn: btn_i, rx: rx_i, ry: ry_i, lx: lx_i, ly: ly_i};

  pad_link_shift u_shift (
    .clk(clk), .rst_n(rst_n), .active(active),
    .sck_fall(s_fall[1]), .sck_rise(s_rise[1]), .mosi_s(s_lvl[2]),
    .load(load), .load_byte(load_byte),
    .miso(miso), .rx_byte(rx_byte), .byte_done(byte_done)
  );

  pad_link_proto u_proto (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start),
    .byte_done(byte_done), .rx_byte(rx_byte), .pad_in(pad_in),
    .load(load), .load_byte(load_byte), .ack_req(ack_req)
  );

  pad_link_ack #(.DELAY(ACK_DELAY), .LEN(ACK_LEN)) u_ack (
    .clk(clk), .rst_n(rst_n), .active(active), .trig(ack_req), .ack_n(ack_n)
  );
endmodule

// File: rtl/pad_link_chk.sv
module pad_link_chk #(
  parameter int ACK_LEN = 6
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic sck,
  input logic miso,
  input logic ack_n,
  input logic cfg,
  input logic analog
);
  logic [2:0] sel_hi_cnt;
  logic [7:0] ack_low_cnt;
  logic [3:0] rise_cnt;
  logic       sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_cnt  <= '0;
      ack_low_cnt <= '0;
      rise_cnt    <= '0;
      sck_prev    <= 1'b1;
    end else begin
      sck_prev <= sck;
      if (!sel_n)                   sel_hi_cnt <= '0;
      else if (sel_hi_cnt != 3'd7)  sel_hi_cnt <= sel_hi_cnt + 3'd1;
      if (ack_n)                    ack_low_cnt <= '0;
      else if (ack_low_cnt != 8'hFF) ack_low_cnt <= ack_low_cnt + 8'd1;
      if (sel_n)                    rise_cnt <= '0;
      else if (sck && !sck_prev && rise_cnt != 4'hF) rise_cnt <= rise_cnt + 4'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi_cnt >= 3'd4) |-> (miso && ack_n));

  // R6
  ack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (ack_low_cnt < 8'(ACK_LEN)));

  // R6
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> (rise_cnt >= 4'd8));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi_cnt >= 3'd4) |-> ($stable(cfg) && $stable(analog)));

  // R8
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (analog != $past(analog)) |-> $past(cfg));
endmodule

bind pad_link_responder pad_link_chk #(.ACK_LEN(ACK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .miso(miso),
  .ack_n(ack_n), .cfg(u_proto.cfg_q), .analog(u_proto.ana_q)
);

// File: tb/pad_link_responder_tb_top.sv
module pad_link_responder_tb_top;
  localparam int HALF = 8;
  localparam int ACKW = 32;
  localparam int ACK_LEN = 6;
  typedef logic [7:0] frame_t [10];

  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sck = 1'b1, mosi = 1'b1;
  logic [15:0] btn = '0;
  logic [7:0] rx = '0, ry = '0, lx = '0, ly = '0;
  logic miso, ack_n;
  int n_chk = 0, n_fail = 0;
  bit m_cfg = 0, m_ana = 0;

  always #2 clk = ~clk;

  pad_link_responder #(.ACK_DELAY(4), .ACK_LEN(ACK_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .mosi(mosi),
    .btn_i(btn), .rx_i(rx), .ry_i(ry), .lx_i(lx), .ly_i(ly),
    .miso(miso), .ack_n(ack_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic frame_t mk(input logic [7:0] lead, input logic [7:0] cmd,
                                input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] fill);
    frame_t f;
    f[0] = lead; f[1] = cmd; f[2] = 8'h00; f[3] = a0; f[4] = a1;
    for (int i = 5; i < 10; i++) f[i] = fill;
    return f;
  endfunction

  function automatic logic [7:0] poll_exp(input int j);
    case (j)
      0: return ~btn[7:0];
      1: return ~btn[15:8];
      2: return rx;
      3: return ry;
      4: return lx;
      default: return ly;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rb, output int lowc);
    rb = '0; lowc = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); mosi = tx[i]; sck = 1'b0;
      wait_clk(HALF);
      @(negedge clk); rb[i] = miso; sck = 1'b1;
      if (i < 7) wait_clk(HALF);
    end
    for (int c = 0; c < ACKW; c++) begin
      @(negedge clk);
      if (!ack_n) lowc++;
    end
  endtask

  task automatic run_frame(input frame_t f, input int n, input int cut);
    logic [7:0] id, rb, exp, arg;
    int len, lowc, expl, kind;
    bit mute;
    string tag;
    id = m_cfg ? 8'hF3 : (m_ana ? 8'h73 : 8'h41);
    len = (m_cfg || m_ana) ? 9 : 5;
    mute = 0; kind = 3; arg = '0;
    @(negedge clk); sel_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      if (cut >= 0 && k == cut) break;
      if (mute)            begin exp = 8'hFF; tag = "R9"; end
      else if (k >= len)   begin exp = 8'hFF; tag = "R11"; end
      else if (k == 0)     begin exp = 8'hFF; tag = "R2"; end
      else if (k == 1)     begin exp = id;    tag = "R3"; end
      else if (k == 2)     begin exp = 8'h5A; tag = "R2"; end
      else if (kind == 0)  begin exp = poll_exp(k - 3); tag = (k < 5) ? "R4" : "R5"; end
      else                 begin exp = 8'h00; tag = "R8"; end
      xfer(f[k], rb, lowc);
      chk(rb == exp, tag, rb, exp);
      if (k == 0 && f[0] != 8'h01) mute = 1;
      if (k == 1) begin
        if (f[1] == 8'h42) kind = 0;
        else if (f[1] == 8'h43) kind = 1;
        else if (f[1] == 8'h44 && m_cfg) kind = 2;
        else kind = 3;
        if (kind == 3) mute = 1;
      end
      if (k == 3) arg = f[3];
      expl = (!mute && k < len - 1) ? ACK_LEN : 0;
      tag = mute ? "R9" : ((k >= len) ? "R11" : "R6");
      chk(lowc == expl, tag, 8'(lowc), 8'(expl));
      if (k == len - 1 && !mute) begin
        if (kind == 1 && arg == 8'h01) m_cfg = 1;          // R7
        if (kind == 1 && arg == 8'h00) m_cfg = 0;
        if (kind == 2 && arg == 8'h01) m_ana = 1;          // R8
        if (kind == 2 && arg == 8'h00) m_ana = 0;
      end
    end
    @(negedge clk); sel_n = 1'b1;
    if (cut >= 0) begin
      wait_clk(5);
      @(negedge clk);
      chk(miso === 1'b1 && ack_n === 1'b1, "R10", {6'd0, miso, ack_n}, 8'h03);
    end
    wait_clk(12);
    @(negedge clk);
    chk(miso === 1'b1 && ack_n === 1'b1, "R1", {6'd0, miso, ack_n}, 8'h03);
  endtask

  task automatic poll_now(input int extra);
    run_frame(mk(8'h01, 8'h42, 8'h00, 8'h00, 8'h00), ((m_cfg || m_ana) ? 9 : 5) + extra, -1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    wait_clk(150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    @(negedge clk);
    // R1 reset state
    chk(miso === 1'b1 && ack_n === 1'b1, "R1", {6'd0, miso, ack_n}, 8'h03);

    btn = 16'h8001; rx = 8'h11; ry = 8'h22; lx = 8'h33; ly = 8'h44;
    poll_now(0);                                             // R4 digital
    btn = 16'h5AA5;
    poll_now(2);                                             // R11 overrun
    run_frame(mk(8'h01, 8'h44, 8'h01, 8'h03, 8'h00), 5, -1); // R9 0x44 not configured
    run_frame(mk(8'h03, 8'h42, 8'h00, 8'h00, 8'h00), 5, -1); // R9 bad lead
    poll_now(0);                                             // still digital
    run_frame(mk(8'h01, 8'h43, 8'h01, 8'h00, 8'h00), 5, -1); // R7 enter
    btn = 16'h00FF; rx = 8'h00; ry = 8'hFF; lx = 8'h80; ly = 8'h7F;
    poll_now(0);                                             // R5 in configuration
    run_frame(mk(8'h01, 8'h44, 8'h01, 8'h03, 8'h00), 9, -1); // R8 analog
    run_frame(mk(8'h01, 8'h43, 8'h00, 8'h5A, 8'h5A), 9, -1); // R7 exit
    poll_now(0);                                             // R3 analog id
    run_frame(mk(8'h01, 8'h43, 8'h01, 8'h00, 8'h00), 9, 5);  // R10 abort after argument
    poll_now(0);                                             // R10 mode unchanged
    run_frame(mk(8'h01, 8'h55, 8'h00, 8'h00, 8'h00), 9, -1); // R9 unknown command
    run_frame(mk(8'h01, 8'h43, 8'h01, 8'h00, 8'h00), 9, -1);
    run_frame(mk(8'h01, 8'h44, 8'h00, 8'h03, 8'h00), 9, -1); // R8 digital
    run_frame(mk(8'h01, 8'h43, 8'h00, 8'h00, 8'h00), 9, -1);
    poll_now(0);                                             // R3 digital again

    for (int it = 0; it < 10; it++) begin
      btn = 16'($urandom); rx = 8'($urandom); ry = 8'($urandom);
      lx = 8'($urandom); ly = 8'($urandom);
      if (it == 4) begin
        run_frame(mk(8'h01, 8'h43, 8'h01, 8'h00, 8'h00), 5, -1);
        run_frame(mk(8'h01, 8'h44, 8'h01, 8'h03, 8'h00), 9, -1);
        run_frame(mk(8'h01, 8'h43, 8'h00, 8'h00, 8'h00), 9, -1);
      end
      poll_now(0);                                           // R4 R5 random
    end

    summary();
    $finish;
  end
endmodule